// File: doc/BRIEF.md
# Priority Interrupt Vector Controller

This block collects eight level-sensitive, active-high interrupt requests, picks the most urgent one, and asks the processor for service on one interrupt line. When the processor acknowledges, the block answers on the data bus with a one-byte restart opcode. Three bits of that opcode hold the vector, so the handler starts at the vector times eight (0x00, 0x08, up to 0x38).

Units can be chained by priority. Each unit's cascade-enable output feeds the cascade-enable input of the next, less urgent unit. A unit fires only while its cascade input is high. It passes the enable on only while it is idle and has nothing pending. In vector-read mode a shared handler receives the all-ones opcode (0xFF, restart to 0x38). That handler then performs an I/O read of the unit, which returns the vector already multiplied by eight.

The controller is a five-state machine:
- `ST_IDLE` waits for an enabled request (transition *arm*).
- `ST_FIRE` emits the one-cycle internal interrupt pulse (transition *latch*).
- `ST_WAIT` holds the interrupt line until acknowledge (transition *capture*).
- `ST_DRIVE` places the acknowledge byte on the bus for one cycle. It then returns to idle (*done*) or, in vector-read mode, goes on to `ST_PORT` (*defer*).
- `ST_PORT` waits for the I/O read and drives the vector byte (*read*).

Top module: `irq_vector_ctrl`

## Requirements
- R1: Request 0 is the most urgent and request 7 the least. The vector is the index of the lowest-numbered request that is high at the acknowledge edge.
- R2: From idle, an enabled request at a clock edge raises `irq_o` after the second edge. `irq_o` then stays high until the edge that samples `ack_i`, and is low after that edge.
- R3: In direct mode (`vec_read_mode_i`=0), the cycle after the acknowledge edge drives `dout_oe_o`=1 for exactly one cycle. The byte is {2'b11, vector[2:0], 3'b111}, that is 0xC7 | vector<<3.
- R4: In vector-read mode (`vec_read_mode_i`=1), the acknowledge byte is 0xFF.
- R5: In vector-read mode, after the acknowledge byte, an `io_rd_i` pulse drives {2'b00, vector[2:0], 3'b000} combinationally in that cycle, with `dout_oe_o`=1. This byte is the handler address.
- R6: `casc_en_o` is high only when `casc_en_i` is high, all requests are low and the unit is idle. With `casc_en_i` low, requests never raise `irq_o`.
- R7: When `dout_oe_o` is low, `dout_o` is 0x00. An `ack_i` received while no interrupt is outstanding is ignored: the bus is not driven.
- R8: The vector is captured at acknowledge, so a more urgent request that arrives between interrupt and acknowledge wins. No new interrupt is raised until the acknowledge sequence, including the vector read in vector-read mode, has finished.
- R9: During and just after reset, `irq_o` and `dout_oe_o` are low and `casc_en_o` equals `casc_en_i` with no requests pending.
- R10: If every request has dropped by the acknowledge edge, the vector is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Level interrupt requests, bit 0 most urgent |
| casc_en_i | input | 1 | Cascade enable from the more urgent unit |
| casc_en_o | output | 1 | Cascade enable to the less urgent unit |
| ack_i | input | 1 | Interrupt acknowledge strobe, one cycle |
| io_rd_i | input | 1 | I/O read strobe of this unit (vector-read mode) |
| vec_read_mode_i | input | 1 | 0: direct opcode, 1: all-ones opcode plus vector read |
| irq_o | output | 1 | Interrupt to the processor |
| dout_o | output | 8 | Data bus byte |
| dout_oe_o | output | 1 | Data bus output enable |

## Verification
The hardest case to reach is a change of request levels inside the window between the interrupt and the acknowledge edge. The same applies to requests held high while a vector read is still owed. The stimulus task applies a second request pattern on the exact cycle it raises `ack_i`. This lets the bench show both a late, more urgent request winning and every request vanishing, which yields vector 7. In vector-read mode the task holds requests high for several cycles in `ST_PORT` before issuing the read, to show that no second interrupt escapes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRE,
        ST_WAIT,
        ST_DRIVE,
        ST_PORT
    } ivc_state_e;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned VEC_SHIFT = 3;

endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int unsigned NREQ  = 8,
    localparam int unsigned VEC_W = $clog2(NREQ)
) (
    input  logic [NREQ-1:0]  req_i,
    output logic             any_o,
    output logic [VEC_W-1:0] idx_o
);

    always_comb begin
        idx_o = VEC_W'(NREQ - 1);
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = VEC_W'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/ivc_byte_fmt.sv
module ivc_byte_fmt
    import irq_vec_pkg::*;
#(
    parameter int unsigned VEC_W = 3
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              alt_i,
    output logic [BYTE_W-1:0] ack_byte_o,
    output logic [BYTE_W-1:0] port_byte_o
);

    localparam logic [BYTE_W-1:0] FIELD =
        BYTE_W'(((1 << VEC_W) - 1) << VEC_SHIFT);

    logic [BYTE_W-1:0] placed;

    always_comb begin
        placed      = BYTE_W'(vec_i) << VEC_SHIFT;
        port_byte_o = placed;
        ack_byte_o  = alt_i ? {BYTE_W{1'b1}} : (~FIELD | placed);
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned NREQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    input  logic            casc_en_i,
    output logic            casc_en_o,
    input  logic            ack_i,
    input  logic            io_rd_i,
    input  logic            vec_read_mode_i,
    output logic            irq_o,
    output logic [7:0]      dout_o,
    output logic            dout_oe_o
);

    localparam int unsigned VEC_W = $clog2(NREQ);

    ivc_state_e        state_q, state_d;
    logic              irq_q;
    logic [VEC_W-1:0]  vec_q;
    logic              alt_q;
    logic              win_any;
    logic [VEC_W-1:0]  win_idx;
    logic [BYTE_W-1:0] ack_byte, port_byte;

    ivc_prio_enc #(.NREQ(NREQ)) u_enc (
        .req_i (req_i),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    ivc_byte_fmt #(.VEC_W(VEC_W)) u_fmt (
        .vec_i       (vec_q),
        .alt_i       (alt_q),
        .ack_byte_o  (ack_byte),
        .port_byte_o (port_byte)
    );

    // state register and captured datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
            vec_q   <= '0;
            alt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FIRE) begin
                irq_q <= 1'b1;
            end else if (state_q == ST_WAIT && ack_i) begin
                irq_q <= 1'b0;
                vec_q <= win_idx;
                alt_q <= vec_read_mode_i;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (casc_en_i && win_any) state_d = ST_FIRE;
            ST_FIRE:  state_d = ST_WAIT;
            ST_WAIT:  if (ack_i) state_d = ST_DRIVE;
            ST_DRIVE: state_d = alt_q ? ST_PORT : ST_IDLE;
            ST_PORT:  if (io_rd_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dout_oe_o = 1'b0;
        dout_o    = '0;
        unique case (state_q)
            ST_DRIVE: begin
                dout_oe_o = 1'b1;
                dout_o    = ack_byte;
            end
            ST_PORT: begin
                if (io_rd_i) begin
                    dout_oe_o = 1'b1;
                    dout_o    = port_byte;
                end
            end
            default: begin
                dout_oe_o = 1'b0;
            end
        endcase
        irq_o     = irq_q;
        casc_en_o = casc_en_i && !win_any && (state_q == ST_IDLE);
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int unsigned NREQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] req_i,
    input logic            casc_en_i,
    input logic            casc_en_o,
    input logic            ack_i,
    input logic            io_rd_i,
    input logic            vec_read_mode_i,
    input logic            irq_o,
    input logic [7:0]      dout_o,
    input logic            dout_oe_o
);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_i |=> irq_o);

    p_ack_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ack_i |=> dout_oe_o && !irq_o);

    p_direct_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o && !vec_read_mode_i |->
            dout_o[7:6] == 2'b11 && dout_o[2:0] == 3'b111);

    p_port_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o && io_rd_i && vec_read_mode_i |->
            dout_o[7:6] == 2'b00 && dout_o[2:0] == 3'b000);

    p_cascade_r6: assert property (@(posedge clk) disable iff (!rst_n)
        casc_en_o |-> casc_en_i && req_i == '0);

    p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |-> dout_o == 8'h00);

    p_no_irq_in_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o |-> !irq_o);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NREQ(NREQ)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req_i),
    .casc_en_i       (casc_en_i),
    .casc_en_o       (casc_en_o),
    .ack_i           (ack_i),
    .io_rd_i         (io_rd_i),
    .vec_read_mode_i (vec_read_mode_i),
    .irq_o           (irq_o),
    .dout_o          (dout_o),
    .dout_oe_o       (dout_oe_o)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       casc_en_i = 1'b1;
    logic       casc_en_o;
    logic       ack_i = 1'b0;
    logic       io_rd_i = 1'b0;
    logic       vec_read_mode_i = 1'b0;
    logic       irq_o;
    logic [7:0] dout_o;
    logic       dout_oe_o;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .casc_en_i       (casc_en_i),
        .casc_en_o       (casc_en_o),
        .ack_i           (ack_i),
        .io_rd_i         (io_rd_i),
        .vec_read_mode_i (vec_read_mode_i),
        .irq_o           (irq_o),
        .dout_o          (dout_o),
        .dout_oe_o       (dout_oe_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: every driven byte must match the head of the queue
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (dout_oe_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected bus drive", dout_o, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(dout_o == e.val, e.tag, dout_o, e.val);
                end
            end
        end
    end

    // driver: one full interrupt service
    task automatic service(input logic [7:0] reqs, input logic [7:0] late,
                           input bit alt, input logic [2:0] v,
                           input int hold, input string tag);
        @(negedge clk);
        vec_read_mode_i = alt;
        req_i = reqs;
        @(negedge clk);
        #1 chk(irq_o == 1'b0, {"R2 irq low after one edge ", tag}, irq_o, 0);
        @(negedge clk);
        #1 chk(irq_o == 1'b1, {"R2 irq high after two edges ", tag}, irq_o, 1);
        @(negedge clk);
        #1 chk(irq_o == 1'b1, {"R2 irq held ", tag}, irq_o, 1);
        @(negedge clk);
        push(alt ? 8'hFF : (8'hC7 | (8'(v) << 3)),
             alt ? {"R4 ack byte ", tag} : {"R3 R1 ack byte ", tag});
        ack_i = 1'b1;
        req_i = late;
        @(negedge clk);
        ack_i = 1'b0;
        #1 chk(irq_o == 1'b0, {"R2 irq cleared ", tag}, irq_o, 0);
        if (alt) begin
            req_i = reqs;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                #1 chk(irq_o == 1'b0, {"R8 no irq before read ", tag}, irq_o, 0);
            end
            @(negedge clk);
            push(8'(v) << 3, {"R5 port byte ", tag});
            io_rd_i = 1'b1;
            req_i = '0;
            @(negedge clk);
            io_rd_i = 1'b0;
        end else begin
            req_i = '0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (2) @(negedge clk);
        #1;
        chk(irq_o == 1'b0, "R9 irq in reset", irq_o, 0);
        chk(dout_oe_o == 1'b0, "R9 oe in reset", dout_oe_o, 0);
        chk(casc_en_o == 1'b1, "R9 cascade out in reset", casc_en_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(irq_o == 1'b0 && dout_oe_o == 1'b0, "R9 idle after reset",
               {irq_o, dout_oe_o}, 0);

        // R7 stray acknowledge ignored
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        #1 chk(dout_oe_o == 1'b0 && dout_o == 8'h00, "R7 stray ack",
               {dout_oe_o, dout_o}, 0);

        // R6 cascade gating
        @(negedge clk);
        casc_en_i = 1'b0;
        req_i = 8'h01;
        repeat (4) @(negedge clk);
        #1;
        chk(irq_o == 1'b0, "R6 disabled unit silent", irq_o, 0);
        chk(casc_en_o == 1'b0, "R6 cascade out low when disabled", casc_en_o, 0);
        @(negedge clk);
        req_i = '0;
        casc_en_i = 1'b1;
        #1 chk(casc_en_o == 1'b1, "R6 cascade out passes enable", casc_en_o, 1);
        req_i = 8'h10;
        #1 chk(casc_en_o == 1'b0, "R6 cascade out blocked by request", casc_en_o, 0);
        req_i = '0;

        // R1 R3 direct mode patterns
        service(8'b1000_0000, 8'b1000_0000, 1'b0, 3'd7, 0, "lone7");
        service(8'b0010_1100, 8'b0010_1100, 1'b0, 3'd2, 0, "mix");
        service(8'hFF,        8'hFF,        1'b0, 3'd0, 0, "all");
        service(8'b0001_0000, 8'b0001_0000, 1'b0, 3'd4, 0, "lone4");
        // R8 more urgent request arriving at acknowledge wins
        service(8'b0010_0000, 8'b0010_0100, 1'b0, 3'd2, 0, "late R8");
        // R10 every request gone at acknowledge
        service(8'b0000_0010, 8'b0000_0000, 1'b0, 3'd7, 0, "vanish R10");
        // R4 R5 vector-read mode
        service(8'b0100_0000, 8'b0100_0000, 1'b1, 3'd6, 0, "alt6");
        service(8'b0000_1010, 8'b0000_1010, 1'b1, 3'd1, 4, "alt1 hold");
        service(8'b0000_0001, 8'b0000_0001, 1'b1, 3'd0, 2, "alt0");

        repeat (4) @(negedge clk);
        #1 chk(exp_q.size() == 0, "R3 all expected bytes produced", exp_q.size(), 0);
        chk(irq_o == 1'b0 && casc_en_o == 1'b1, "R6 idle at end",
            {irq_o, casc_en_o}, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule